// File: doc/BRIEF.md
# Synchronous Burst ROM Read Engine

This block is the read side of a single-bank synchronous read-only memory. Commands and the multiplexed row/column address are taken from a small set of active-low strobes on the rising clock edge. A row activate opens a row, and that row stays open until the next activate. A read then starts a burst of 4 or 8 words from the open row. The burst follows either a sequential or an interleaved column order and reaches the data outputs after a programmable CAS latency. There are no precharge, refresh or power-up steps. After reset the block is ready for either an activate or a mode-register load.

The array contents are computed from the address rather than stored. The word-select input picks 32-bit or 16-bit organisation for each read, and this changes the width of the column address. A per-half output-enable pair stands in for the high-impedance state of the data pins. A clock-enable input freezes the internal clock for one cycle, which gives burst suspend and idle power-down. An output-mask input blanks data with a fixed lag.

Top module: `sbr_rom_read`

## Requirements
- R1: A command is taken only on a rising edge where `cs_ni` is low and the edge is not frozen (see R9). The strobe patterns `{ras_ni,cas_ni,mset_ni}` decode as follows: 3'b011 is row activate (`addr_i` is the row), 3'b101 is read, and 3'b110 is mode load. Every other pattern is a no-operation.
- R2: The mode register resets to CAS latency 6, burst length 4, sequential order and activate-to-read delay 2. A mode load takes its fields from `addr_i`:
  - bits [2:0] set the burst length: 3'b010 gives 4 and 3'b011 gives 8.
  - bit 3 sets the order: 0 is sequential and 1 is interleaved.
  - bits [6:4] set the CAS latency: 4, 5 or 6.
  - bit 7 sets the delay: 0 gives 1 cycle and 1 gives 2 cycles.
  
  A burst-length or latency code outside these values leaves that field unchanged.
- R3: A read is accepted only when a row has been activated since reset and at least the programmed delay (1 or 2 unfrozen edges) has passed since the last activate. Any other read produces no data and raises `err_o` for exactly the one cycle after that edge.
- R4: For a read accepted at edge E, beat 0 appears on the outputs during the cycle after the unfrozen edge E+CL-1. Beat i appears one unfrozen edge after beat i-1.
- R5: A burst has 4 or 8 beats. Column bits above the burst field are kept from the start column. For beat i, the burst field is `(start+i) mod BL` in sequential order and `start XOR i` in interleaved order.
- R6: When `wide_i` is high during the read command, the column is `addr_i[7:0]` and each beat is one 32-bit word. When it is low, the column is `addr_i[8:0]`. Each beat is then bits [15:0] (column bit 0 = 0) or bits [31:16] (column bit 0 = 1) of the 32-bit word at column `[8:1]`, presented on `dq_o[15:0]`.
- R7: The 32-bit word at row r and 32-bit column c is `{3'b000, r[12:0], c[7:0]^8'h55, c[7:0]}`.
- R8: `dq_oe_o[0]` enables the lower half and `dq_oe_o[1]` enables the upper half. Both are low outside read data cycles. `dq_oe_o[1]` is low in 16-bit reads. `dq_o` is zero in every half that is not enabled.
- R9: When `cke_i` is low at edge n, edge n+1 is frozen. On a frozen edge, outputs, burst progress, the mask pipeline and the mode register all hold, and no command is taken.
- R10: When `dqm_i` is high at an unfrozen edge n, both enables are low during the cycle after edge n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable for the following edge |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| mset_ni | input | 1 | Mode-load strobe, active low |
| addr_i | input | 13 | Multiplexed row/column/mode address |
| dqm_i | input | 1 | Output mask, two-edge lag |
| wide_i | input | 1 | 1: 32-bit, 0: 16-bit organisation |
| dq_o | output | 32 | Read data |
| dq_oe_o | output | 2 | Output enable per 16-bit half |
| err_o | output | 1 | One-cycle pulse on a rejected read |

## Verification
Corrupted latency or burst-counter state shows up as enables that rise one cycle early or late, or as a burst that ends at the wrong beat. Each of these is visible within CL+8 cycles of the read. A wrong order or start-column latch shows up on the first misplaced beat as a column byte that does not match the expected sequence, because each word embeds its own column. Errors in the mask or suspend pipelines move the blanked or held cycle by one. A stale row-open or delay counter shows up on the next read as an `err_o` pulse that is missing or spurious.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {CMD_NOP, CMD_ACT, CMD_RD, CMD_MRS} cmd_e;

  typedef struct packed {
    logic [2:0] cl;
    logic       bl8;
    logic       ilv;
    logic       rcd2;
  } mode_t;

  localparam mode_t MODE_RST = '{cl: 3'd6, bl8: 1'b0, ilv: 1'b0, rcd2: 1'b1};
  localparam logic [2:0] BL4_CODE = 3'b010;
  localparam logic [2:0] BL8_CODE = 3'b011;

  function automatic cmd_e decode_cmd(logic cs_n, logic ras_n, logic cas_n, logic ms_n);
    if (cs_n) return CMD_NOP;
    case ({ras_n, cas_n, ms_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b110:  return CMD_MRS;
      default: return CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/sbr_mode_reg.sv
module sbr_mode_reg import sbr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] field_i,
  output mode_t      mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_RST;
    end else if (load_i) begin
      if (field_i[2:0] == BL4_CODE)      mode_o.bl8 <= 1'b0;
      else if (field_i[2:0] == BL8_CODE) mode_o.bl8 <= 1'b1;
      if (field_i[6:4] >= 3'd4 && field_i[6:4] <= 3'd6) mode_o.cl <= field_i[6:4];
      mode_o.ilv  <= field_i[3];
      mode_o.rcd2 <= field_i[7];
    end
  end
endmodule

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic [2:0]    cl_i,
  input  logic          bl8_i,
  input  logic          ilv_i,
  input  logic          wide_i,
  input  logic [CW-1:0] col_i,
  output logic          beat_o,
  output logic          wide_o,
  output logic [CW-1:0] col_o
);
  localparam int BB = 3;

  logic          pend_q, run_q, bl8_q, ilv_q;
  logic [2:0]    dly_q;
  logic [BB-1:0] idx_q;
  logic [CW-1:0] col_q;
  logic [BB-1:0] idx_now, mask, base, low;

  assign idx_now = pend_q ? '0 : idx_q;
  assign mask    = bl8_q ? 3'd7 : 3'd3;
  assign base    = col_q[BB-1:0] & mask;
  assign low     = ilv_q ? (base ^ idx_now) : ((base + idx_now) & mask);
  assign col_o   = {col_q[CW-1:BB], (col_q[BB-1:0] & ~mask) | low};
  assign beat_o  = en_i && ((pend_q && dly_q == 3'd1) || run_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      dly_q  <= '0;
      idx_q  <= '0;
      col_q  <= '0;
      bl8_q  <= 1'b0;
      ilv_q  <= 1'b0;
      wide_o <= 1'b1;
    end else if (en_i) begin
      if (start_i) begin
        pend_q <= 1'b1;
        run_q  <= 1'b0;
        dly_q  <= cl_i - 3'd1;
        idx_q  <= '0;
        col_q  <= col_i;
        bl8_q  <= bl8_i;
        ilv_q  <= ilv_i;
        wide_o <= wide_i;
      end else if (pend_q) begin
        if (dly_q == 3'd1) begin
          pend_q <= 1'b0;
          run_q  <= 1'b1;
          idx_q  <= 3'd1;
        end else begin
          dly_q <= dly_q - 3'd1;
        end
      end else if (run_q) begin
        if (idx_q == mask) run_q <= 1'b0;
        idx_q <= idx_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/sbr_rom_array.sv
module sbr_rom_array #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int PAD_W = DATA_W - ROW_W - 2 * COL_W;
  localparam logic [COL_W-1:0] SALT = {(COL_W / 2){2'b01}};

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_o = {{PAD_W{1'b0}}, row_i, col_i ^ SALT, col_i};
    end else begin : g_nopad
      assign word_o = {row_i, col_i ^ SALT, col_i};
    end
  endgenerate
endmodule

// File: rtl/sbr_rom_read.sv
module sbr_rom_read import sbr_pkg::*; #(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              mset_ni,
  input  logic [ROW_W-1:0]  addr_i,
  input  logic              dqm_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [1:0]        dq_oe_o,
  output logic              err_o
);
  localparam int CW   = COL_W + 1;
  localparam int HALF = DATA_W / 2;

  logic              cke_q, en;
  cmd_e              cmd;
  mode_t             mode;
  logic [ROW_W-1:0]  row_q, rd_row_q;
  logic              row_open_q, rcd_wait_q, rd_ok;
  logic [CW-1:0]     col_in, beat_col;
  logic              beat, beat_wide;
  logic [COL_W-1:0]  word_col;
  logic [DATA_W-1:0] word, dq_q;
  logic              valid_q, wide_out_q, dqm1_q, dqm2_q;

  assign en  = cke_q;
  assign cmd = decode_cmd(cs_ni, ras_ni, cas_ni, mset_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  sbr_mode_reg i_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (en && cmd == CMD_MRS),
    .field_i(addr_i[7:0]),
    .mode_o (mode)
  );

  assign rd_ok = en && cmd == CMD_RD && row_open_q && !rcd_wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q      <= '0;
      rd_row_q   <= '0;
      row_open_q <= 1'b0;
      rcd_wait_q <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      err_o <= en && cmd == CMD_RD && !rd_ok;
      if (en) begin
        if (cmd == CMD_ACT) begin
          row_q      <= addr_i;
          row_open_q <= 1'b1;
          rcd_wait_q <= mode.rcd2;
        end else begin
          rcd_wait_q <= 1'b0;
        end
        if (rd_ok) rd_row_q <= row_q;
      end
    end
  end

  assign col_in = wide_i ? {1'b0, addr_i[COL_W-1:0]} : addr_i[CW-1:0];

  sbr_burst_seq #(.CW(CW)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .start_i(rd_ok),
    .cl_i   (mode.cl),
    .bl8_i  (mode.bl8),
    .ilv_i  (mode.ilv),
    .wide_i (wide_i),
    .col_i  (col_in),
    .beat_o (beat),
    .wide_o (beat_wide),
    .col_o  (beat_col)
  );

  assign word_col = beat_wide ? beat_col[COL_W-1:0] : beat_col[CW-1:1];

  sbr_rom_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) i_array (
    .row_i (rd_row_q),
    .col_i (word_col),
    .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      wide_out_q <= 1'b0;
      dq_q       <= '0;
      dqm1_q     <= 1'b0;
      dqm2_q     <= 1'b0;
    end else if (en) begin
      valid_q <= beat;
      dqm1_q  <= dqm_i;
      dqm2_q  <= dqm1_q;
      if (beat) begin
        wide_out_q <= beat_wide;
        if (beat_wide)        dq_q <= word;
        else if (beat_col[0]) dq_q <= {{HALF{1'b0}}, word[DATA_W-1:HALF]};
        else                  dq_q <= {{HALF{1'b0}}, word[HALF-1:0]};
      end
    end
  end

  assign dq_oe_o = {valid_q && !dqm2_q && wide_out_q, valid_q && !dqm2_q};
  assign dq_o    = dq_oe_o[0] ? dq_q : '0;
endmodule

// File: rtl/sbr_rom_read_chk.sv
module sbr_rom_read_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic              cs_ni,
  input logic              ras_ni,
  input logic              cas_ni,
  input logic              mset_ni,
  input logic              dqm_i,
  input logic [DATA_W-1:0] dq_o,
  input logic [1:0]        dq_oe_o,
  input logic              err_o
);
  logic cke_d, act_seen, rd_cmd, act_cmd;

  assign rd_cmd  = !cs_ni && ras_ni && !cas_ni && mset_ni;
  assign act_cmd = !cs_ni && !ras_ni && cas_ni && mset_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_d    <= 1'b1;
      act_seen <= 1'b0;
    end else begin
      cke_d <= cke_i;
      if (act_cmd && cke_d) act_seen <= 1'b1;
    end
  end

  // R3: read without an open row is flagged
  a_r3_norow_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && cke_d && !act_seen) |=> err_o);

  // R3: the flag only follows an accepted read strobe
  a_r3_err_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_cmd && cke_d));

  // R9: a frozen edge changes no output
  a_r9_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |-> ##2 ($stable(dq_o) && $stable(dq_oe_o)));

  // R10: mask lands after the second edge
  a_r10_mask_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqm_i && cke_d && cke_i) |-> ##2 (dq_oe_o == 2'b00));
endmodule

bind sbr_rom_read sbr_rom_read_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cke_i  (cke_i),
  .cs_ni  (cs_ni),
  .ras_ni (ras_ni),
  .cas_ni (cas_ni),
  .mset_ni(mset_ni),
  .dqm_i  (dqm_i),
  .dq_o   (dq_o),
  .dq_oe_o(dq_oe_o),
  .err_o  (err_o)
);

// File: tb/test_sbr_rom_read.sv
`timescale 1ns/1ps
module test_sbr_rom_read;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, ms_n = 1'b1;
  logic [12:0] addr = '0;
  logic        dqm = 1'b0, wide = 1'b1;
  logic [31:0] dq;
  logic [1:0]  oe;
  logic        err;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  sbr_rom_read i_sbr_rom_read (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .mset_ni(ms_n), .addr_i(addr), .dqm_i(dqm), .wide_i(wide),
    .dq_o(dq), .dq_oe_o(oe), .err_o(err)
  );

  // row, col, wide, ilv, bl8, cl, rcd2
  localparam logic [28:0] VEC [6] = '{
    {13'h0123, 9'h00A, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0},
    {13'h1FFF, 9'h0FE, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1},
    {13'h0040, 9'h1F3, 1'b0, 1'b0, 1'b1, 3'd6, 1'b0},
    {13'h0A5A, 9'h005, 1'b0, 1'b1, 1'b0, 3'd4, 1'b1},
    {13'h0000, 9'h0FF, 1'b1, 1'b0, 1'b1, 3'd6, 1'b1},
    {13'h1234, 9'h1FE, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(logic r, logic c, logic m, logic [12:0] a);
    cs_n = 1'b0; ras_n = r; cas_n = c; ms_n = m; addr = a;
    tick();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; ms_n = 1'b1; addr = '0;
  endtask

  task automatic mode_set(logic [2:0] cl, logic ilv, logic bl8, logic rcd2);
    cmd(1'b1, 1'b1, 1'b0, {5'b0, rcd2, cl, ilv, bl8 ? 3'b011 : 3'b010});
  endtask

  // R7 word, R5 order, R6 organisation
  function automatic logic [33:0] exp_beat(logic [12:0] row, logic [8:0] col, logic w,
                                           logic ilv, logic bl8, int i);
    logic [8:0] m, c0, c;
    logic [7:0] c8;
    logic [31:0] wd;
    m  = bl8 ? 9'd7 : 9'd3;
    c0 = w ? {1'b0, col[7:0]} : col;
    c  = (c0 & ~m) | (ilv ? ((c0 & m) ^ 9'(i)) : (((c0 & m) + 9'(i)) & m));
    c8 = w ? c[7:0] : c[8:1];
    wd = {3'b000, row, c8 ^ 8'h55, c8};
    if (w) return {2'b11, wd};
    return {2'b01, 16'h0, c[0] ? wd[31:16] : wd[15:0]};
  endfunction

  task automatic burst_check(logic [12:0] row, logic [8:0] col, logic w, logic ilv,
                             logic bl8, int cl, string tag);
    for (int k = 1; k < cl; k++) begin
      chk({"R4 quiet before latency ", tag}, {err, oe, dq}, 35'h0);
      tick();
    end
    for (int i = 0; i < (bl8 ? 8 : 4); i++) begin
      chk({"R4 R5 R6 R7 R8 beat ", tag}, {1'b0, oe, dq}, {1'b0, exp_beat(row, col, w, ilv, bl8, i)});
      tick();
    end
    chk({"R5 R8 burst end ", tag}, {err, oe, dq}, 35'h0);
  endtask

  task automatic run_case(logic [12:0] row, logic [8:0] col, logic w, logic ilv, logic bl8,
                          logic [2:0] cl, logic rcd2, logic do_mode, string tag);
    if (do_mode) mode_set(cl, ilv, bl8, rcd2);
    cmd(1'b0, 1'b1, 1'b1, row);
    if (rcd2) tick();
    wide = w;
    cmd(1'b1, 1'b0, 1'b1, {4'b0, col});
    burst_check(row, col, w, ilv, bl8, int'(cl), tag);
  endtask

  initial begin
    #750us;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R8 reset outputs", {err, oe, dq}, 35'h0);
    rst_n = 1'b1;
    tick();
    chk("R8 idle after reset", {err, oe, dq}, 35'h0);

    // R3: read with no open row
    cmd(1'b1, 1'b0, 1'b1, 13'h004);
    chk("R3 no-row read flagged", {34'h0, err}, 35'h1);
    tick();
    chk("R3 flag one cycle", {34'h0, err}, 35'h0);
    for (int k = 0; k < 8; k++) begin
      chk("R3 no data after rejected read", {err, oe, dq}, 35'h0);
      tick();
    end

    // R2: default mode CL6 BL4 sequential delay 2
    run_case(13'h0005, 9'h003, 1'b1, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0, "R2 default");

    // R1 decode through table walk
    for (int v = 0; v < 6; v++) begin
      run_case(VEC[v][28:16], VEC[v][15:7], VEC[v][6], VEC[v][5], VEC[v][4],
               VEC[v][3:1], VEC[v][0], 1'b1, $sformatf("R1 vec%0d", v));
    end

    // R3: read one edge after activate with delay 2
    mode_set(3'd4, 1'b0, 1'b0, 1'b1);
    cmd(1'b0, 1'b1, 1'b1, 13'h0077);
    wide = 1'b1;
    cmd(1'b1, 1'b0, 1'b1, 13'h010);
    chk("R3 early read flagged", {34'h0, err}, 35'h1);
    tick();
    for (int k = 0; k < 8; k++) begin
      chk("R3 no data after early read", {err, oe, dq}, 35'h0);
      tick();
    end

    // R2: reserved codes keep CL4 and BL4, order/delay still load
    mode_set(3'd4, 1'b0, 1'b0, 1'b0);
    cmd(1'b1, 1'b1, 1'b0, {5'b0, 1'b0, 3'd7, 1'b1, 3'b000});
    run_case(13'h0333, 9'h021, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, "R2 reserved codes");

    // R1: deselected strobes ignored
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b0; ms_n = 1'b1; addr = 13'h001;
    tick();
    ras_n = 1'b1; cas_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk("R1 deselected read ignored", {err, oe, dq}, 35'h0);
      tick();
    end

    // R10: mask sampled at E0+3 blanks beat 1
    mode_set(3'd4, 1'b0, 1'b0, 1'b0);
    cmd(1'b0, 1'b1, 1'b1, 13'h0101);
    wide = 1'b1;
    cmd(1'b1, 1'b0, 1'b1, 13'h040);
    tick(); tick();
    dqm = 1'b1;
    tick();
    chk("R10 beat0 before mask", {1'b0, oe, dq}, {1'b0, exp_beat(13'h0101, 9'h040, 1'b1, 1'b0, 1'b0, 0)});
    dqm = 1'b0;
    tick();
    chk("R10 beat1 masked", {1'b0, oe, dq}, 35'h0);
    tick();
    chk("R10 beat2 after mask", {1'b0, oe, dq}, {1'b0, exp_beat(13'h0101, 9'h040, 1'b1, 1'b0, 1'b0, 2)});
    tick();
    chk("R10 beat3", {1'b0, oe, dq}, {1'b0, exp_beat(13'h0101, 9'h040, 1'b1, 1'b0, 1'b0, 3)});
    tick();
    chk("R10 end", {err, oe, dq}, 35'h0);

    // R9: clock-enable low freezes beat0 one extra cycle
    cmd(1'b0, 1'b1, 1'b1, 13'h0202);
    cmd(1'b1, 1'b0, 1'b1, 13'h013);
    tick(); tick();
    cke = 1'b0;
    tick();
    chk("R9 beat0", {1'b0, oe, dq}, {1'b0, exp_beat(13'h0202, 9'h013, 1'b1, 1'b0, 1'b0, 0)});
    cke = 1'b1;
    tick();
    chk("R9 beat0 held on frozen edge", {1'b0, oe, dq}, {1'b0, exp_beat(13'h0202, 9'h013, 1'b1, 1'b0, 1'b0, 0)});
    for (int i = 1; i < 4; i++) begin
      tick();
      chk("R9 beats resume", {1'b0, oe, dq}, {1'b0, exp_beat(13'h0202, 9'h013, 1'b1, 1'b0, 1'b0, i)});
    end
    tick();
    chk("R9 end", {err, oe, dq}, 35'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule